// File: doc/BRIEF.md
# Shared Timer/Watchdog Prescaler Unit

This block holds an 8-bit event timer and a watchdog counter that share a single 8-bit divider. One assignment bit decides which consumer owns the divider. When the timer owns it, the divider sits in front of the timer and slows its count by a selectable power of two. When the watchdog owns it, it sits after the watchdog overflow and stretches the time-out period instead. Only one consumer can hold the divider at any moment.

The timer counts either instruction-cycle ticks or edges seen on an external clock pin, with the active edge of that pin selectable. Every count event passes through a two-stage synchronizer that advances on the instruction tick before it reaches the timer. A write to the timer loads it. A watchdog-clear strobe restarts the watchdog. Each of these also wipes the shared divider when it belongs to that consumer. A rollover of the timer sets a sticky flag. The watchdog time-out output is a single-cycle pulse and is gated by an enable input.

Top module: `tmr_wdt_prescaler`

## Requirements
- R1: After reset, `tmr_q` is 0x00, `tmr_ovf` is 0 and `wdt_timeout` is 0.
- R2: `cfg[5]` selects the timer source. At 0 every `icyc_tick` is a count event and the external pin has no effect. At 1 only edges of `ext_pin` count and `icyc_tick` alone does not advance `tmr_q`.
- R3: `cfg[4]` sets the active pin edge. At 0 a rising edge of `ext_pin` counts and a falling edge does not. At 1 a falling edge counts and a rising edge does not.
- R4: With `cfg[3]`=0 the divider feeds the timer, and `tmr_q` advances once per 2^(`cfg[2:0]`+1) count events. Each divided event reaches `tmr_q` at the second `icyc_tick` after the tick that captured it. Starting from a timer write with `icyc_tick` as the source, N ticks therefore add floor((N-2)/2^(`cfg[2:0]`+1)).
- R5: With `cfg[3]`=1 the timer is undivided and every captured count event adds one, with the same two-tick latency.
- R6: A `tmr_wr` pulse loads `tmr_wdata` into `tmr_q` and discards pending count events. While `cfg[3]`=0 it also clears the divider count.
- R7: With `cfg[3]`=0, `wdt_timeout` pulses for one cycle every 2^WDT_W `wdt_tick` pulses. With `cfg[3]`=1 it pulses every 2^(WDT_W+`cfg[2:0]`) `wdt_tick` pulses.
- R8: `wdt_clr` restarts the watchdog counter. While `cfg[3]`=1 it also clears the divider count.
- R9: While `wdt_en` is 0, `wdt_timeout` stays 0.
- R10: `tmr_ovf` is set when `tmr_q` advances from 0xFF to 0x00. It stays set across later counts until `flag_clr` is pulsed.
- R11: Any change of `cfg[3]` clears the divider count in the cycle of the change, so no partial count moves from one consumer to the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| icyc_tick | input | 1 | One-cycle pulse per instruction cycle |
| ext_pin | input | 1 | External timer clock pin (asynchronous) |
| wdt_tick | input | 1 | Free-running watchdog base tick |
| wdt_en | input | 1 | Watchdog time-out enable |
| cfg | input | 6 | [5] source, [4] edge, [3] assignment, [2:0] ratio |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | TMR_W | Timer write data |
| flag_clr | input | 1 | Clears the overflow flag |
| wdt_clr | input | 1 | Watchdog restart strobe |
| tmr_q | output | TMR_W | Timer value |
| tmr_ovf | output | 1 | Sticky timer overflow flag |
| wdt_timeout | output | 1 | One-cycle watchdog time-out pulse |

## Verification
The timer is driven with instruction-tick runs at several ratio settings, including the smallest and largest divide. Comparing those runs with the undivided run separates the tap choice from the assignment routing. Single rising and falling pin transitions under both edge settings show which edge counts and that the pin and the tick cannot substitute for each other. The watchdog is run for long tick trains with and without the divider, and with clears placed mid-period. An assignment flip placed after a partial count shows whether leftover divider state leaks from one consumer to the other.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int PS_W = 3;

  typedef struct packed {
    logic            src_ext;   // 1: external pin, 0: instruction tick
    logic            edge_inv;  // 1: falling edge of pin counts
    logic            to_wdt;    // 1: divider owned by watchdog
    logic [PS_W-1:0] ratio;     // divider tap select
  } tp_cfg_t;

  localparam int CFG_W = $bits(tp_cfg_t);
endpackage

// File: rtl/tp_src_sel.sv
module tp_src_sel (
  input  logic clk,
  input  logic rst,
  input  logic ext_pin,
  input  logic edge_inv,
  input  logic src_ext,
  input  logic icyc_tick,
  output logic evt
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= ext_pin ^ edge_inv;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign evt = src_ext ? (s2 & ~s3) : icyc_tick;
endmodule

// File: rtl/tp_prescaler.sv
module tp_prescaler #(
  parameter int PRE_W = 8,
  parameter int PS_W  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            adv,
  input  logic            to_wdt,
  input  logic [PS_W-1:0] ratio,
  output logic            fire
);
  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] mask;
  int               taps;

  always_comb begin
    taps = to_wdt ? int'(ratio) : int'(ratio) + 1;
    for (int i = 0; i < PRE_W; i++) mask[i] = (i < taps);
  end

  assign fire = adv & ~clr & ((cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (adv)   cnt <= cnt + PRE_W'(1);
  end

  a_r11_ps_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(cnt));
endmodule

// File: rtl/tp_tmr_core.sv
module tp_tmr_core #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             icyc_tick,
  input  logic             inc_evt,
  input  logic             wr,
  input  logic [TMR_W-1:0] wdata,
  input  logic             flag_clr,
  output logic [TMR_W-1:0] tmr_q,
  output logic             flag
);
  logic pend, sync1, sync2;
  logic bump;

  assign bump = icyc_tick & sync2 & ~wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q <= '0;
      pend  <= 1'b0;
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else if (wr) begin
      tmr_q <= wdata;
      pend  <= 1'b0;
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else if (icyc_tick) begin
      if (sync2) tmr_q <= tmr_q + TMR_W'(1);
      sync2 <= sync1;
      sync1 <= pend | inc_evt;
      pend  <= 1'b0;
    end else begin
      pend <= pend | inc_evt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      flag <= 1'b0;
    else if (bump && &tmr_q)      flag <= 1'b1;
    else if (flag_clr)            flag <= 1'b0;
  end

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr && !icyc_tick) |=> $stable(tmr_q));
  a_r10_flag_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> ($past(tmr_q) == {TMR_W{1'b1}} && tmr_q == '0));
endmodule

// File: rtl/tp_wdt_core.sv
module tp_wdt_core #(
  parameter int WDT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic wdt_tick,
  input  logic wdt_clr,
  output logic ovf
);
  logic [WDT_W-1:0] cnt;

  assign ovf = wdt_tick & ~wdt_clr & (&cnt);

  always_ff @(posedge clk) begin
    if (rst || wdt_clr) cnt <= '0;
    else if (wdt_tick)  cnt <= cnt + WDT_W'(1);
  end

  a_r8_wdt_clear: assert property (@(posedge clk) disable iff (rst)
    wdt_clr |=> (cnt == '0));
endmodule

// File: rtl/tmr_wdt_prescaler.sv
module tmr_wdt_prescaler
  import tp_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int PRE_W = 8,
  parameter int WDT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             icyc_tick,
  input  logic             ext_pin,
  input  logic             wdt_tick,
  input  logic             wdt_en,
  input  logic [CFG_W-1:0] cfg,
  input  logic             tmr_wr,
  input  logic [TMR_W-1:0] tmr_wdata,
  input  logic             flag_clr,
  input  logic             wdt_clr,
  output logic [TMR_W-1:0] tmr_q,
  output logic             tmr_ovf,
  output logic             wdt_timeout
);
  tp_cfg_t c;
  logic    psa_q, psa_chg;
  logic    src_evt, wdt_ovf, ps_adv, ps_clr, ps_fire;
  logic    inc_evt, wdt_evt;

  assign c       = tp_cfg_t'(cfg);
  assign psa_chg = psa_q ^ c.to_wdt;

  always_ff @(posedge clk) begin
    if (rst) psa_q <= 1'b0;
    else     psa_q <= c.to_wdt;
  end

  tp_src_sel u_src (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .edge_inv(c.edge_inv),
    .src_ext(c.src_ext), .icyc_tick(icyc_tick), .evt(src_evt)
  );

  tp_wdt_core #(.WDT_W(WDT_W)) u_wdt (
    .clk(clk), .rst(rst), .wdt_tick(wdt_tick), .wdt_clr(wdt_clr), .ovf(wdt_ovf)
  );

  assign ps_adv = c.to_wdt ? wdt_ovf : src_evt;
  assign ps_clr = psa_chg | (~c.to_wdt & tmr_wr) | (c.to_wdt & wdt_clr);

  tp_prescaler #(.PRE_W(PRE_W), .PS_W(PS_W)) u_ps (
    .clk(clk), .rst(rst), .clr(ps_clr), .adv(ps_adv),
    .to_wdt(c.to_wdt), .ratio(c.ratio), .fire(ps_fire)
  );

  assign inc_evt = c.to_wdt ? src_evt : ps_fire;
  assign wdt_evt = c.to_wdt ? ps_fire : wdt_ovf;

  tp_tmr_core #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .icyc_tick(icyc_tick), .inc_evt(inc_evt),
    .wr(tmr_wr), .wdata(tmr_wdata), .flag_clr(flag_clr),
    .tmr_q(tmr_q), .flag(tmr_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) wdt_timeout <= 1'b0;
    else     wdt_timeout <= wdt_en & wdt_evt;
  end

  a_r9_enable_gate: assert property (@(posedge clk) disable iff (rst)
    wdt_timeout |-> $past(wdt_en));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wdt_timeout |=> !wdt_timeout);
endmodule

// File: tb/tmr_wdt_prescaler_bench.sv
module tmr_wdt_prescaler_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       icyc_tick = 1'b0, ext_pin = 1'b0, wdt_tick = 1'b0, wdt_en = 1'b0;
  logic [5:0] cfg = 6'd0;
  logic       tmr_wr = 1'b0, flag_clr = 1'b0, wdt_clr = 1'b0;
  logic [7:0] tmr_wdata = 8'd0;
  logic [7:0] tmr_q;
  logic       tmr_ovf, wdt_timeout;

  int nvec = 0, nbad = 0;
  int mon = 0;
  logic mon_clr = 1'b0;

  always #5 clk = ~clk;

  tmr_wdt_prescaler u_tmr_wdt_prescaler (
    .clk(clk), .rst(rst), .icyc_tick(icyc_tick), .ext_pin(ext_pin),
    .wdt_tick(wdt_tick), .wdt_en(wdt_en), .cfg(cfg), .tmr_wr(tmr_wr),
    .tmr_wdata(tmr_wdata), .flag_clr(flag_clr), .wdt_clr(wdt_clr),
    .tmr_q(tmr_q), .tmr_ovf(tmr_ovf), .wdt_timeout(wdt_timeout)
  );

  always @(posedge clk) begin
    if (mon_clr) mon <= 0;
    else if (wdt_timeout) mon <= mon + 1;
  end

  task automatic check(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) icyc_tick = 1'b1;
      @(negedge clk) icyc_tick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic wr_tmr(logic [7:0] v);
    @(negedge clk) begin tmr_wr = 1'b1; tmr_wdata = v; end
    @(negedge clk) tmr_wr = 1'b0;
  endtask

  task automatic set_cfg(logic [5:0] v);
    @(negedge clk) cfg = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic pin(logic v);
    @(negedge clk) ext_pin = v;
    repeat (4) @(negedge clk);
    ticks(3);
  endtask

  task automatic wclr();
    @(negedge clk) wdt_clr = 1'b1;
    @(negedge clk) wdt_clr = 1'b0;
  endtask

  task automatic mclr();
    @(negedge clk) mon_clr = 1'b1;
    @(negedge clk) mon_clr = 1'b0;
  endtask

  task automatic wdog(int k);
    @(negedge clk) wdt_tick = 1'b1;
    repeat (k) @(negedge clk);
    wdt_tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 tmr", tmr_q, 0);
    check("R1 flag", tmr_ovf, 0);
    check("R1 timeout", wdt_timeout, 0);
  endtask

  task automatic t_ratio();
    set_cfg(6'b000_000);  // tick source, divider on timer, 1:2
    wr_tmr(8'h00); ticks(12);
    check("R4 ratio 1:2", tmr_q, 5);
    set_cfg(6'b000_010);  // 1:8
    wr_tmr(8'h00); ticks(34);
    check("R4 ratio 1:8", tmr_q, 4);
    set_cfg(6'b000_111);  // 1:256
    wr_tmr(8'h00); ticks(514);
    check("R4 ratio 1:256", tmr_q, 2);
  endtask

  task automatic t_undivided();
    set_cfg(6'b001_101);
    wr_tmr(8'h20); ticks(10);
    check("R5 undivided", tmr_q, 8'h28);
  endtask

  task automatic t_write_clear();
    set_cfg(6'b000_010);  // 1:8
    wr_tmr(8'h00); ticks(6);
    wr_tmr(8'h10); ticks(9);
    check("R6 write load + divider clear", tmr_q, 8'h10);
  endtask

  task automatic t_source();
    set_cfg(6'b000_000);
    wr_tmr(8'h00);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) ext_pin = 1'b1;
      repeat (3) @(negedge clk);
      ext_pin = 1'b0;
      repeat (3) @(negedge clk);
    end
    ticks(6);
    check("R2 tick source ignores pin", tmr_q, 2);
    set_cfg(6'b101_000);  // pin source, undivided, rising edge
    wr_tmr(8'h00); ticks(5);
    check("R2 pin source ignores ticks", tmr_q, 0);
  endtask

  task automatic t_edge();
    set_cfg(6'b101_000);
    wr_tmr(8'h00);
    pin(1'b1);
    check("R3 rising counts", tmr_q, 1);
    pin(1'b0);
    check("R3 falling ignored", tmr_q, 1);
    pin(1'b1);
    set_cfg(6'b111_000);  // falling edge, pin high so no spurious edge
    pin(1'b0);
    check("R3 falling counts", tmr_q, 3);
    pin(1'b1);
    check("R3 rising ignored", tmr_q, 3);
    set_cfg(6'b111_000);
  endtask

  task automatic t_overflow();
    @(negedge clk) ext_pin = 1'b0;
    set_cfg(6'b001_000);
    wr_tmr(8'hFE); ticks(3);
    check("R10 at 0xFF", tmr_q, 8'hFF);
    check("R10 flag low", tmr_ovf, 0);
    ticks(1);
    check("R10 rollover", tmr_q, 0);
    check("R10 flag set", tmr_ovf, 1);
    ticks(2);
    check("R10 sticky", tmr_ovf, 1);
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    check("R10 cleared", tmr_ovf, 0);
  endtask

  task automatic t_wdt();
    wdt_en = 1'b1;
    set_cfg(6'b000_000);
    wclr(); mclr(); wdog(600);
    check("R7 raw period", mon, 2);
    set_cfg(6'b001_010);  // divider on watchdog, 1:4
    wclr(); mclr(); wdog(2058);
    check("R7 postscaled period", mon, 2);
    set_cfg(6'b000_000);
    wclr(); mclr(); wdog(200); wclr(); wdog(200);
    check("R8 counter restart", mon, 0);
    set_cfg(6'b001_001);  // 1:2 on watchdog
    wclr(); mclr(); wdog(256); wclr(); wdog(256);
    check("R8 divider cleared by restart", mon, 0);
    wdt_en = 1'b0;
    set_cfg(6'b000_000);
    wclr(); mclr(); wdog(600);
    check("R9 disabled", mon, 0);
    wdt_en = 1'b1;
  endtask

  task automatic t_swap();
    set_cfg(6'b001_000);
    wclr();
    set_cfg(6'b000_000);
    ticks(1);             // divider now holds a partial count
    set_cfg(6'b001_001);  // swap to watchdog, 1:2
    mclr(); wdog(256);
    check("R11 swap clears divider", mon, 0);
    wdog(256);
    check("R11 divider runs after swap", mon, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ratio();
    t_undivided();
    t_write_clear();
    t_source();
    t_edge();
    t_overflow();
    t_wdt();
    t_swap();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nvec++; nbad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule